// File: doc/BRIEF.md
# Power Domain Sequencer with Subsystem Resets

This block switches on-chip power domains on and off through a fixed series of steps and owns the software reset lines of the subsystems. Each domain has three controls: power-down enable bits (a set bit removes the rail), isolator-release bits (a set bit disables the isolators) and an active-low reset line. The controls are described by per-domain mask parameters. A host issues commands over a simple register bus. For each command the block changes one control at a time and leaves a programmable number of idle cycles between changes, so that rails and resets can settle.

Taking a domain down clamps its isolators first, then pulls its reset low, and only then removes power. Bringing it up runs the opposite order. The same engine also produces a self-timed reset pulse on any single line. The pulse clears the bit and then sets it again, with the programmed gap between the two edges. While a sequence runs, new commands and direct reset-register writes are refused, and a sticky error flag records any refused command.

The register map, at byte offsets, is as follows. 0x00 is the command register (write only). 0x04 is status. 0x08 is the step gap. 0x10 reads the power-down bits and 0x14 the isolator-release bits. 0x30 is the reset register (read and write). 0x34 is the pulse command (write only).

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, the outputs and registers hold their parameter values: power-down bits 4'b1000, isolator-release bits 2'b10, reset register 32'hFFFE_FFFF, step gap 16. Busy and error are 0. Status (0x04) reads busy in bit 0, error in bit 1 and domain d "on" in bit 8+d.
- R2: Domain d reads "on" exactly when every power-down bit in its power mask is clear. The default masks are: domain 0 uses power bit 3, isolator bit 0 and reset line 16; domain 1 uses power bit 2, isolator bit 1 and reset line 18; domain 2 uses power bit 0, no isolator bit and reset line 20.
- R3: A command write to 0x00 with bit 8 = 0 and the domain index in bits 7:0 powers the domain off. The steps run in this order: clear its isolator bits, then clear its reset bit, then set its power bits. Each step changes only that domain's bits.
- R4: A command with bit 8 = 1 powers the domain on. The steps run in this order: clear its power bits, then set its reset bit, then set its isolator bits.
- R5: The first step takes effect on the clock edge after the command is accepted. With a gap value W, consecutive applied steps lie W+1 edges apart. At most one of the three control groups changes on any edge.
- R6: A step whose mask is zero is skipped. It changes nothing and costs one edge, with no gap added after it.
- R7: Busy (status bit 0) is high from the acceptance edge through the edge of the final step. A command or pulse written while busy is dropped and sets the sticky error bit. Writing 1 to status bit 1 clears the error bit.
- R8: A write to the reset register at 0x30 loads all 32 bits when the block is idle and has no effect while a sequence runs. The gap register at 0x08 also accepts writes only when idle.
- R9: A write to 0x34 with line N in bits 4:0 clears reset bit N and then sets it W+1 edges later, leaving every other bit unchanged. Busy is high for the duration of the pulse.
- R10: A command naming a domain index of 3 or more is dropped, sets the error bit and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwr_down_o | output | 4 | Power-down enables, 1 = rail off |
| iso_rel_o | output | 2 | Isolator releases, 1 = isolators disabled |
| sub_rst_n_o | output | 32 | Subsystem resets, 0 = held in reset |
| busy_o | output | 1 | Sequence in progress |
| dom_on_o | output | 3 | Per-domain powered status |

## Verification
The hardest situation to reach is a collision: a second command, a pulse request or a direct reset write that arrives while a sequence is still inside its wait gap. The bench makes the gap long (16 cycles) and issues the competing writes on the cycles right after acceptance. It then checks that the sequence finishes with the reset register it alone would produce, and that the error bit is set. The skip path needs a domain with an empty isolator mask; powering that domain off with a short gap shows that the skipped step costs exactly one edge before the reset step.

// File: rtl/pwrseq_pkg.sv
// Shared constants and types for the power domain sequencer.
// Assumes an 8-bit byte-offset register bus.
package pwrseq_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h04;
    localparam logic [ADDR_W-1:0] A_GAP   = 8'h08;
    localparam logic [ADDR_W-1:0] A_PWR   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ISO   = 8'h14;
    localparam logic [ADDR_W-1:0] A_RST   = 8'h30;
    localparam logic [ADDR_W-1:0] A_PULSE = 8'h34;

    typedef enum logic [1:0] {
        OP_OFF   = 2'd0,
        OP_ON    = 2'd1,
        OP_PULSE = 2'd2
    } seq_op_t;

    typedef enum logic [1:0] {
        TGT_PWR = 2'd0,
        TGT_RST = 2'd1,
        TGT_ISO = 2'd2
    } step_tgt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_t;
endpackage

// File: rtl/pwrseq_decode.sv
// Bus write decoder: turns register writes into engine commands, host
// reset writes and gap updates, and keeps the sticky error flag.
// Assumes DATA_W >= RST_W and that a write lasts one cycle of bus_valid.
module pwrseq_decode
    import pwrseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RST_W     = 32,
    parameter int WAIT_W    = 16,
    parameter int NDOM      = 3,
    parameter int WAIT_INIT = 16,
    localparam int DOM_W    = (NDOM > 1) ? $clog2(NDOM) : 1,
    localparam int LINE_W   = $clog2(RST_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    output logic              cmd_go,
    output seq_op_t           cmd_op,
    output logic [DOM_W-1:0]  cmd_dom,
    output logic [RST_W-1:0]  pulse_mask,
    output logic              host_rst_we,
    output logic [RST_W-1:0]  host_rst_data,
    output logic [WAIT_W-1:0] gap_cfg,
    output logic              err
);
    logic wr, wr_cmd, wr_pulse, wr_rst, wr_gap, wr_stat;
    logic dom_ok, err_set, err_clr;
    logic [WAIT_W-1:0] gap_q;
    logic err_q;

    // Address decode of write strobes.
    always_comb begin
        wr       = bus_valid & bus_write;
        wr_cmd   = wr & (bus_addr == A_CMD);
        wr_pulse = wr & (bus_addr == A_PULSE);
        wr_rst   = wr & (bus_addr == A_RST);
        wr_gap   = wr & (bus_addr == A_GAP);
        wr_stat  = wr & (bus_addr == A_STAT);
    end

    // Command acceptance and rejection.
    always_comb begin
        dom_ok        = 32'(bus_wdata[7:0]) < 32'(NDOM);
        cmd_go        = ~busy & ((wr_cmd & dom_ok) | wr_pulse);
        cmd_op        = wr_pulse ? OP_PULSE : (bus_wdata[8] ? OP_ON : OP_OFF);
        cmd_dom       = bus_wdata[DOM_W-1:0];
        pulse_mask    = RST_W'(1) << bus_wdata[LINE_W-1:0];
        host_rst_we   = wr_rst & ~busy;
        host_rst_data = bus_wdata[RST_W-1:0];
        err_set       = (wr_cmd & (busy | ~dom_ok)) | (wr_pulse & busy);
        err_clr       = wr_stat & bus_wdata[1];
    end

    // Sticky error flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // Step gap register, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_q <= WAIT_W'(WAIT_INIT);
        else if (wr_gap && !busy) gap_q <= bus_wdata[WAIT_W-1:0];
    end

    assign gap_cfg = gap_q;
    assign err     = err_q;
endmodule

// File: rtl/pwrseq_timer.sv
// Down-counter that spaces sequence steps; expired is high when it is zero.
// Assumes load and countdown never happen in the same cycle (load wins).
module pwrseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_engine.sv
// Step engine: latches a command's masks and walks the power-off, power-on
// or pulse step list, emitting one control action per applied step.
// Assumes cmd_go is only raised while idle and cmd_dom is in range.
module pwrseq_engine
    import pwrseq_pkg::*;
#(
    parameter int NDOM   = 3,
    parameter int PWR_W  = 4,
    parameter int ISO_W  = 2,
    parameter int RST_W  = 32,
    parameter int WAIT_W = 16,
    parameter logic [NDOM-1:0][PWR_W-1:0] DOM_PWR_MASK = '0,
    parameter logic [NDOM-1:0][ISO_W-1:0] DOM_ISO_MASK = '0,
    parameter logic [NDOM-1:0][RST_W-1:0] DOM_RST_MASK = '0,
    localparam int DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  seq_op_t           cmd_op,
    input  logic [DOM_W-1:0]  cmd_dom,
    input  logic [RST_W-1:0]  pulse_mask,
    input  logic [WAIT_W-1:0] gap_cfg,
    output logic              busy,
    output logic              act_valid,
    output step_tgt_t         act_tgt,
    output logic              act_set,
    output logic [RST_W-1:0]  act_mask
);
    eng_state_t       state_q;
    seq_op_t          op_q;
    logic [1:0]       step_q;
    logic [PWR_W-1:0] pm_q;
    logic [ISO_W-1:0] im_q;
    logic [RST_W-1:0] rm_q;
    logic             last, fire, apply, expired, t_load;
    logic [WAIT_W-1:0] t_val;

    // Select the target and direction of the current step.
    always_comb begin
        act_tgt = TGT_RST;
        act_set = 1'b1;
        unique case (op_q)
            OP_OFF: begin
                act_set = (step_q == 2'd2);
                act_tgt = (step_q == 2'd0) ? TGT_ISO :
                          (step_q == 2'd1) ? TGT_RST : TGT_PWR;
            end
            OP_ON: begin
                act_set = (step_q != 2'd0);
                act_tgt = (step_q == 2'd0) ? TGT_PWR :
                          (step_q == 2'd1) ? TGT_RST : TGT_ISO;
            end
            default: begin
                act_set = (step_q != 2'd0);
                act_tgt = TGT_RST;
            end
        endcase
    end

    // Mask of the current step and the step-firing conditions.
    always_comb begin
        unique case (act_tgt)
            TGT_PWR: act_mask = RST_W'(pm_q);
            TGT_ISO: act_mask = RST_W'(im_q);
            default: act_mask = rm_q;
        endcase
        last      = (op_q == OP_PULSE) ? (step_q == 2'd1) : (step_q == 2'd2);
        fire      = (state_q == ST_RUN) & expired;
        apply     = fire & (act_mask != '0);
        act_valid = apply;
        t_load    = cmd_go | (apply & ~last);
        t_val     = cmd_go ? '0 : gap_cfg;
    end

    pwrseq_timer #(.W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (expired)
    );

    // Sequence state: accept a command, advance a step each time one fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_OFF;
            step_q  <= 2'd0;
            pm_q    <= '0;
            im_q    <= '0;
            rm_q    <= '0;
        end else if (cmd_go) begin
            state_q <= ST_RUN;
            op_q    <= cmd_op;
            step_q  <= 2'd0;
            if (cmd_op == OP_PULSE) begin
                pm_q <= '0;
                im_q <= '0;
                rm_q <= pulse_mask;
            end else begin
                pm_q <= DOM_PWR_MASK[cmd_dom];
                im_q <= DOM_ISO_MASK[cmd_dom];
                rm_q <= DOM_RST_MASK[cmd_dom];
            end
        end else if (fire) begin
            if (last) begin
                state_q <= ST_IDLE;
                step_q  <= 2'd0;
            end else begin
                step_q  <= step_q + 2'd1;
            end
        end
    end

    assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/pwrseq_regs.sv
// Control registers for power-down, isolator-release and reset lines.
// Each engine action is a read-modify-write limited to its mask; host
// reset writes arrive only while the engine is idle.
module pwrseq_regs
    import pwrseq_pkg::*;
#(
    parameter int PWR_W = 4,
    parameter int ISO_W = 2,
    parameter int RST_W = 32,
    parameter logic [PWR_W-1:0] PWR_INIT = '0,
    parameter logic [ISO_W-1:0] ISO_INIT = '0,
    parameter logic [RST_W-1:0] RST_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  step_tgt_t        act_tgt,
    input  logic             act_set,
    input  logic [RST_W-1:0] act_mask,
    input  logic             host_we,
    input  logic [RST_W-1:0] host_data,
    output logic [PWR_W-1:0] pwr,
    output logic [ISO_W-1:0] iso,
    output logic [RST_W-1:0] rst
);
    logic [PWR_W-1:0] pwr_q;
    logic [ISO_W-1:0] iso_q;
    logic [RST_W-1:0] rst_q;

    // Power-down bits: set removes power.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= PWR_INIT;
        else if (act_valid && act_tgt == TGT_PWR)
            pwr_q <= act_set ? (pwr_q | act_mask[PWR_W-1:0])
                             : (pwr_q & ~act_mask[PWR_W-1:0]);
    end

    // Isolator-release bits: set disables the isolators.
    always_ff @(posedge clk) begin
        if (!rst_n) iso_q <= ISO_INIT;
        else if (act_valid && act_tgt == TGT_ISO)
            iso_q <= act_set ? (iso_q | act_mask[ISO_W-1:0])
                             : (iso_q & ~act_mask[ISO_W-1:0]);
    end

    // Active-low reset lines: engine steps or idle host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= RST_INIT;
        else if (act_valid && act_tgt == TGT_RST)
            rst_q <= act_set ? (rst_q | act_mask) : (rst_q & ~act_mask);
        else if (host_we)
            rst_q <= host_data;
    end

    assign pwr = pwr_q;
    assign iso = iso_q;
    assign rst = rst_q;
endmodule

// File: rtl/pwrseq_ctrl.sv
// Top of the power domain sequencer: register bus, step engine and control
// registers. Reads are combinational on bus_addr. Assumes RST_W == DATA_W
// and that PWR_W and ISO_W do not exceed RST_W.
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NDOM      = 3,
    parameter int PWR_W     = 4,
    parameter int ISO_W     = 2,
    parameter int RST_W     = 32,
    parameter int WAIT_W    = 16,
    parameter int WAIT_INIT = 16,
    parameter logic [NDOM-1:0][PWR_W-1:0] DOM_PWR_MASK = {4'b0001, 4'b0100, 4'b1000},
    parameter logic [NDOM-1:0][ISO_W-1:0] DOM_ISO_MASK = {2'b00, 2'b10, 2'b01},
    parameter logic [NDOM-1:0][RST_W-1:0] DOM_RST_MASK =
        {32'h0010_0000, 32'h0004_0000, 32'h0001_0000},
    parameter logic [PWR_W-1:0] PWR_INIT = 4'b1000,
    parameter logic [ISO_W-1:0] ISO_INIT = 2'b10,
    parameter logic [RST_W-1:0] RST_INIT = 32'hFFFE_FFFF,
    localparam int DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PWR_W-1:0]  pwr_down_o,
    output logic [ISO_W-1:0]  iso_rel_o,
    output logic [RST_W-1:0]  sub_rst_n_o,
    output logic              busy_o,
    output logic [NDOM-1:0]   dom_on_o
);
    logic              cmd_go, host_rst_we, err_q, busy;
    seq_op_t           cmd_op;
    logic [DOM_W-1:0]  cmd_dom;
    logic [RST_W-1:0]  pulse_mask, host_rst_data, act_mask;
    logic [WAIT_W-1:0] gap_cfg;
    logic              act_valid, act_set;
    step_tgt_t         act_tgt;
    logic [DATA_W-1:0] stat_word;

    pwrseq_decode #(
        .DATA_W(DATA_W), .RST_W(RST_W), .WAIT_W(WAIT_W),
        .NDOM(NDOM), .WAIT_INIT(WAIT_INIT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_dom(cmd_dom),
        .pulse_mask(pulse_mask), .host_rst_we(host_rst_we),
        .host_rst_data(host_rst_data), .gap_cfg(gap_cfg), .err(err_q)
    );

    pwrseq_engine #(
        .NDOM(NDOM), .PWR_W(PWR_W), .ISO_W(ISO_W), .RST_W(RST_W),
        .WAIT_W(WAIT_W), .DOM_PWR_MASK(DOM_PWR_MASK),
        .DOM_ISO_MASK(DOM_ISO_MASK), .DOM_RST_MASK(DOM_RST_MASK)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_dom(cmd_dom),
        .pulse_mask(pulse_mask), .gap_cfg(gap_cfg), .busy(busy),
        .act_valid(act_valid), .act_tgt(act_tgt), .act_set(act_set),
        .act_mask(act_mask)
    );

    pwrseq_regs #(
        .PWR_W(PWR_W), .ISO_W(ISO_W), .RST_W(RST_W),
        .PWR_INIT(PWR_INIT), .ISO_INIT(ISO_INIT), .RST_INIT(RST_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_tgt(act_tgt), .act_set(act_set),
        .act_mask(act_mask), .host_we(host_rst_we), .host_data(host_rst_data),
        .pwr(pwr_down_o), .iso(iso_rel_o), .rst(sub_rst_n_o)
    );

    // Per-domain powered status: on when none of its power-down bits is set.
    for (genvar d = 0; d < NDOM; d++) begin : g_dom_on
        assign dom_on_o[d] = ((pwr_down_o & DOM_PWR_MASK[d]) == '0);
    end

    // Status word layout: busy, error, domain flags from bit 8.
    always_comb begin
        stat_word = '0;
        stat_word[0] = busy;
        stat_word[1] = err_q;
        stat_word[8 +: NDOM] = dom_on_o;
    end

    // Combinational read mux.
    always_comb begin
        unique case (bus_addr)
            A_STAT:  bus_rdata = stat_word;
            A_GAP:   bus_rdata = DATA_W'(gap_cfg);
            A_PWR:   bus_rdata = DATA_W'(pwr_down_o);
            A_ISO:   bus_rdata = DATA_W'(iso_rel_o);
            A_RST:   bus_rdata = DATA_W'(sub_rst_n_o);
            default: bus_rdata = '0;
        endcase
    end

    assign busy_o = busy;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
// Assertion checker for pwrseq_ctrl, attached with bind. Observes ports and
// the internal error flag; assumes reset is held for at least one edge.
module pwrseq_ctrl_chk
    import pwrseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NDOM   = 3,
    parameter int PWR_W  = 4,
    parameter int ISO_W  = 2,
    parameter int RST_W  = 32,
    parameter logic [NDOM-1:0][PWR_W-1:0] DOM_PWR_MASK = '0,
    parameter logic [NDOM-1:0][ISO_W-1:0] DOM_ISO_MASK = '0,
    parameter logic [NDOM-1:0][RST_W-1:0] DOM_RST_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              err,
    input logic [PWR_W-1:0]  pwr,
    input logic [ISO_W-1:0]  iso,
    input logic [RST_W-1:0]  rst
);
    logic wr_any, rst_wr, cmd_wr, err_clr_wr;
    assign wr_any     = bus_valid & bus_write;
    assign rst_wr     = wr_any & (bus_addr == A_RST);
    assign cmd_wr     = wr_any & ((bus_addr == A_CMD) | (bus_addr == A_PULSE));
    assign err_clr_wr = wr_any & (bus_addr == A_STAT) & bus_wdata[1];

    // R8: reset lines only move during a sequence or after an idle host write.
    assert_rst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(rst_wr)) |-> $stable(rst));

    // R5: never more than one control group changes on one edge.
    assert_one_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pwr != $past(pwr), iso != $past(iso), rst != $past(rst)}) <= 1);

    // R7: a command or pulse while busy raises the error flag.
    assert_busy_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> err);

    // R7: the error flag stays set until cleared by a status write.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr_wr) |=> err);

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        // R3: power removal only with the domain isolated and in reset.
        assert_off_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (((pwr & ~$past(pwr) & DOM_PWR_MASK[d]) != '0)) |->
            (((iso & DOM_ISO_MASK[d]) == '0) && ((rst & DOM_RST_MASK[d]) == '0)));
        // R4: isolator release only with the domain powered and out of reset.
        assert_on_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (((iso & ~$past(iso) & DOM_ISO_MASK[d]) != '0)) |->
            (((pwr & DOM_PWR_MASK[d]) == '0) &&
             ((rst & DOM_RST_MASK[d]) == DOM_RST_MASK[d])));
    end
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
    .DATA_W(DATA_W), .NDOM(NDOM), .PWR_W(PWR_W), .ISO_W(ISO_W), .RST_W(RST_W),
    .DOM_PWR_MASK(DOM_PWR_MASK), .DOM_ISO_MASK(DOM_ISO_MASK),
    .DOM_RST_MASK(DOM_RST_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy_o), .err(err_q),
    .pwr(pwr_down_o), .iso(iso_rel_o), .rst(sub_rst_n_o)
);

// File: tb/test_pwrseq_ctrl.sv
// Directed bench for pwrseq_ctrl: one task per scenario, each checking
// its own results at falling edges against a bench-side model.
module test_pwrseq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwr_down_o;
    logic [1:0]  iso_rel_o;
    logic [31:0] sub_rst_n_o;
    logic        busy_o;
    logic [2:0]  dom_on_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwrseq_ctrl i_pwrseq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_down_o(pwr_down_o), .iso_rel_o(iso_rel_o), .sub_rst_n_o(sub_rst_n_o),
        .busy_o(busy_o), .dom_on_o(dom_on_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the falling edge after the accepting edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(8'h10, v); chk("R1 pwr", v, 32'h8);
        rd(8'h14, v); chk("R1 iso", v, 32'h2);
        rd(8'h30, v); chk("R1 rst", v, 32'hFFFE_FFFF);
        rd(8'h08, v); chk("R1 gap", v, 32'd16);
        rd(8'h04, v); chk("R1/R2 status", v, 32'h600);
        chk("R2 dom_on", {29'b0, dom_on_o}, 32'h6);
    endtask

    task automatic t_on_dom0();
        logic [31:0] v;
        wr(8'h08, 32'd3);
        wr(8'h00, 32'h100);
        chk("R7 busy at accept", {31'b0, busy_o}, 32'h1);
        chk("R5 nothing at accept", {28'b0, pwr_down_o}, 32'h8);
        step(1);
        chk("R4 step1 pwr clear", {28'b0, pwr_down_o}, 32'h0);
        chk("R4 step1 rst held", sub_rst_n_o, 32'hFFFE_FFFF);
        step(3);
        chk("R5 gap holds rst", sub_rst_n_o, 32'hFFFE_FFFF);
        step(1);
        chk("R4 step2 rst release", sub_rst_n_o, 32'hFFFF_FFFF);
        chk("R4 step2 iso held", {30'b0, iso_rel_o}, 32'h2);
        step(3);
        chk("R7 busy mid", {31'b0, busy_o}, 32'h1);
        step(1);
        chk("R4 step3 iso release", {30'b0, iso_rel_o}, 32'h3);
        chk("R7 busy drops on last step", {31'b0, busy_o}, 32'h0);
        rd(8'h04, v); chk("R2 status all on", v, 32'h700);
    endtask

    task automatic t_off_dom1();
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h001);
        step(1);
        chk("R3 step1 iso clamp", {30'b0, iso_rel_o}, 32'h1);
        chk("R3 step1 rst held", sub_rst_n_o, 32'hFFFF_FFFF);
        step(1);
        chk("R3 step2 rst assert", sub_rst_n_o, 32'hFFFB_FFFF);
        chk("R3 step2 pwr held", {28'b0, pwr_down_o}, 32'h0);
        step(1);
        chk("R3 step3 pwr off", {28'b0, pwr_down_o}, 32'h4);
        chk("R5 gap0 done", {31'b0, busy_o}, 32'h0);
        chk("R2 dom1 off", {29'b0, dom_on_o}, 32'h5);
    endtask

    task automatic t_skip_dom2();
        wr(8'h08, 32'd2);
        wr(8'h00, 32'h002);
        step(1);
        chk("R6 skipped iso step", {30'b0, iso_rel_o}, 32'h1);
        chk("R6 rst untouched at skip", sub_rst_n_o, 32'hFFFB_FFFF);
        step(1);
        chk("R6 rst right after skip", sub_rst_n_o, 32'hFFEB_FFFF);
        step(2);
        chk("R6 pwr waits gap", {28'b0, pwr_down_o}, 32'h4);
        step(1);
        chk("R6 pwr off", {28'b0, pwr_down_o}, 32'h5);
        chk("R6 done", {31'b0, busy_o}, 32'h0);
    endtask

    task automatic t_pulse();
        wr(8'h34, 32'd5);
        step(1);
        chk("R9 pulse low", sub_rst_n_o, 32'hFFEB_FFDF);
        chk("R9 busy in pulse", {31'b0, busy_o}, 32'h1);
        step(2);
        chk("R9 pulse still low", sub_rst_n_o, 32'hFFEB_FFDF);
        step(1);
        chk("R9 pulse high", sub_rst_n_o, 32'hFFEB_FFFF);
        chk("R9 idle after", {31'b0, busy_o}, 32'h0);
    endtask

    task automatic t_busy_reject();
        logic [31:0] v;
        wr(8'h08, 32'd16);
        wr(8'h00, 32'h101);
        wr(8'h00, 32'h100);
        wr(8'h30, 32'h0);
        wr(8'h34, 32'd3);
        wr(8'h08, 32'd1);
        step(40);
        chk("R4 dom1 on pwr", {28'b0, pwr_down_o}, 32'h1);
        chk("R8 host write ignored while busy", sub_rst_n_o, 32'hFFEF_FFFF);
        chk("R4 dom1 iso", {30'b0, iso_rel_o}, 32'h3);
        rd(8'h08, v); chk("R8 gap write ignored while busy", v, 32'd16);
        rd(8'h04, v); chk("R7 error sticky", v, 32'h302);
        wr(8'h04, 32'h2);
        rd(8'h04, v); chk("R7 error cleared", v, 32'h300);
    endtask

    task automatic t_bad_dom();
        logic [31:0] v;
        wr(8'h00, 32'h103);
        chk("R10 no busy", {31'b0, busy_o}, 32'h0);
        rd(8'h04, v); chk("R10 error set", v, 32'h302);
        step(3);
        chk("R10 pwr unchanged", {28'b0, pwr_down_o}, 32'h1);
        wr(8'h04, 32'h2);
    endtask

    task automatic t_host_rst();
        logic [31:0] v;
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, v); chk("R8 idle host write", v, 32'h1234_5678);
        chk("R8 output", sub_rst_n_o, 32'h1234_5678);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset_state();
        t_on_dom0();
        t_off_dom1();
        t_skip_dom2();
        t_pulse();
        t_busy_reject();
        t_bad_dom();
        t_host_rst();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule